// File: doc/BRIEF.md
# Reaction Time Measurement Controller

This block times how fast a person answers a visual cue. When the arm button is pressed, the display value is cleared to zero. The unit then waits for a pseudo-random number of milliseconds before it turns on the cue lamp. From that moment it counts whole milliseconds until the person presses the halt button. The result is kept as four binary-coded decimal digits, so a display driver can show it without converting it.

A free-running 16-bit linear feedback shift register supplies the random wait. Its value is captured when the unit is armed and mapped into a configurable window, which by default runs from 1000 to 10000 ms. A divider derived from the clock frequency parameter produces a one-millisecond tick, and that tick paces both the wait and the measurement. If the halt button is pressed before the cue appears, the run ends as a false start and an error pattern is shown. If nobody answers within 1000 ms, the count stops at 1000 and a timeout is reported. Both buttons reach the block as single-cycle pulses that have already been debounced.

Top module: `rt_reaction_timer`

## Requirements
- R1: After reset, `bcd_o` is 16'h0000, and `stim_o`, `done_o`, `timeout_o` and `false_start_o` are all 0.
- R2: A `start_i` pulse in any state re-arms the unit. On the following cycle, `bcd_o` is 16'h0000, `done_o`, `timeout_o` and `false_start_o` are 0, and `stim_o` is 0.
- R3: `stim_o` rises exactly D*TICK_DIV clock cycles after the edge that samples `start_i`, where TICK_DIV = CLK_HZ/1000 and D lies in [MIN_DELAY_MS, MIN_DELAY_MS+DELAY_SPAN_MS-1]. D is taken from the shift register, whose state is never zero.
- R4: While `stim_o` is 1, `bcd_o` shows the number of whole milliseconds elapsed since `stim_o` rose, in BCD. Bits [3:0] hold the units digit, [7:4] the tens, [11:8] the hundreds and [15:12] the thousands.
- R5: A `stop_i` pulse while `stim_o` is 1 drives `done_o` to 1 and `stim_o` to 0 on the next cycle and freezes `bcd_o`. If the stop and a millisecond tick fall on the same edge, the stop wins and the count is not incremented.
- R6: If no stop arrives, the count reaches 1000. `bcd_o` then shows 16'h1000, and `done_o` and `timeout_o` go to 1.
- R7: A `stop_i` pulse during the random wait ends the run. `bcd_o` shows 16'h9999, `false_start_o` and `done_o` go to 1, and `stim_o` stays 0 until the next start.
- R8: `stop_i` has no effect when the unit is idle or done: `bcd_o` and all flags keep their values.
- R9: When `start_i` and `stop_i` are both 1 in the same cycle, the start takes effect and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Debounced arm pulse |
| stop_i | input | 1 | Debounced response pulse |
| stim_o | output | 1 | Cue lamp, high while measuring |
| bcd_o | output | 16 | Four BCD digits of the result |
| done_o | output | 1 | Run finished |
| timeout_o | output | 1 | Run ended at the 1000 ms limit |
| false_start_o | output | 1 | Response came before the cue |

## Verification
The assertions assume that `start_i` and `stop_i` are clean pulses, each sampled once per press, and that nothing changes them between clock edges. Under that assumption, a stop seen while the cue is lit is a genuine response and ends the run on the next cycle. The bench changes both buttons only on falling clock edges and holds each one high for exactly one cycle. The only exception is the deliberate case where start and stop are raised together. The bench also shortens the clock frequency and the delay window through parameters, so the random wait stays within a few dozen cycles. The 1000 ms measurement window and its BCD limit stay unchanged.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_MEASURE,
        ST_DONE
    } rt_state_e;

    typedef struct packed {
        logic timeout;
        logic false_start;
    } rt_flags_t;

    localparam int          DECADES     = 4;
    localparam int          BCD_W       = 4 * DECADES;
    localparam logic [15:0] CODE_LIMIT  = 16'h1000;
    localparam logic [15:0] CODE_LAST   = 16'h0999;
    localparam logic [15:0] CODE_ERROR  = 16'h9999;
    localparam logic [15:0] LFSR_TAPS   = 16'hB400;

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] value
);
    import rt_pkg::*;

    logic [15:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= (SEED == 16'h0) ? 16'h0001 : SEED;
        else     state_q <= lfsr_next(state_q);
    end

    assign value = state_q;
endmodule

// File: rtl/rt_bcd_counter.sv
module rt_bcd_counter #(
    parameter int NUM_DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    load_err,
    input  logic                    inc,
    output logic [4*NUM_DIGITS-1:0] value
);
    logic [NUM_DIGITS:0] carry;

    assign carry[0] = inc;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_decade
        logic [3:0] dig_q;

        assign carry[g+1] = carry[g] && (dig_q == 4'd9);

        always_ff @(posedge clk) begin
            if (rst || clr)     dig_q <= 4'd0;
            else if (load_err)  dig_q <= 4'd9;
            else if (carry[g])  dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
        end

        assign value[4*g +: 4] = dig_q;
    end
endmodule

// File: rtl/rt_reaction_timer.sv
module rt_reaction_timer #(
    parameter int          CLK_HZ        = 100_000_000,
    parameter int          MIN_DELAY_MS  = 1000,
    parameter int          DELAY_SPAN_MS = 9001,
    parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        stop_i,
    output logic        stim_o,
    output logic [15:0] bcd_o,
    output logic        done_o,
    output logic        timeout_o,
    output logic        false_start_o
);
    import rt_pkg::*;

    localparam int TICK_DIV = CLK_HZ / 1000;
    localparam int DW       = $clog2(MIN_DELAY_MS + DELAY_SPAN_MS + 1);

    rt_state_e     state_q;
    rt_flags_t     flags_q;
    logic [DW-1:0] remain_q;
    logic [15:0]   rnd;
    logic [31:0]   pick;
    logic          tick;
    logic          cnt_clr, cnt_err, cnt_inc;
    logic [15:0]   count;

    rt_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk (clk),
        .rst (rst),
        .clr (start_i),
        .tick(tick)
    );

    rt_lfsr #(.SEED(LFSR_SEED)) i_lfsr (
        .clk  (clk),
        .rst  (rst),
        .value(rnd)
    );

    rt_bcd_counter #(.NUM_DIGITS(DECADES)) i_count (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .load_err(cnt_err),
        .inc     (cnt_inc),
        .value   (count)
    );

    assign pick    = {16'h0, rnd} % 32'(DELAY_SPAN_MS);
    assign cnt_clr = start_i;
    assign cnt_err = !start_i && (state_q == ST_WAIT) && stop_i;
    assign cnt_inc = !start_i && (state_q == ST_MEASURE) && !stop_i && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            flags_q  <= '0;
            remain_q <= '0;
        end else if (start_i) begin
            state_q  <= ST_WAIT;
            flags_q  <= '0;
            remain_q <= DW'(MIN_DELAY_MS) + DW'(pick);
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (stop_i) begin
                        state_q             <= ST_DONE;
                        flags_q.false_start <= 1'b1;
                    end else if (tick) begin
                        if (remain_q == DW'(1)) state_q <= ST_MEASURE;
                        else                    remain_q <= remain_q - 1'b1;
                    end
                end
                ST_MEASURE: begin
                    if (stop_i) begin
                        state_q <= ST_DONE;
                    end else if (tick && count == CODE_LAST) begin
                        state_q         <= ST_DONE;
                        flags_q.timeout <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign stim_o        = (state_q == ST_MEASURE);
    assign done_o        = (state_q == ST_DONE);
    assign timeout_o     = flags_q.timeout;
    assign false_start_o = flags_q.false_start;
    assign bcd_o         = count;
endmodule

// File: rtl/rt_reaction_timer_chk.sv
module rt_reaction_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        stop_i,
    input logic        stim_o,
    input logic [15:0] bcd_o,
    input logic        done_o,
    input logic        timeout_o,
    input logic        false_start_o,
    input logic [15:0] rnd
);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (bcd_o == 16'h0000) && !done_o && !stim_o && !timeout_o && !false_start_o);

    assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        rnd != 16'h0000);

    assert_digits_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (bcd_o[3:0] <= 4'd9) && (bcd_o[7:4] <= 4'd9) &&
        (bcd_o[11:8] <= 4'd9) && (bcd_o[15:12] <= 4'd9));

    assert_lamp_not_done_R4: assert property (@(posedge clk) disable iff (rst)
        !(stim_o && done_o));

    assert_stop_freezes_R5: assert property (@(posedge clk) disable iff (rst)
        (stim_o && stop_i && !start_i) |=> done_o && !stim_o && (bcd_o == $past(bcd_o)));

    assert_timeout_value_R6: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> done_o && (bcd_o == 16'h1000));

    assert_false_start_code_R7: assert property (@(posedge clk) disable iff (rst)
        false_start_o |-> done_o && !stim_o && (bcd_o == 16'h9999));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o && $stable(bcd_o) && $stable(timeout_o) && $stable(false_start_o));
endmodule

bind rt_reaction_timer rt_reaction_timer_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .stim_o       (stim_o),
    .bcd_o        (bcd_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o),
    .false_start_o(false_start_o),
    .rnd          (rnd)
);

// File: tb/test_rt_reaction_timer.sv
`timescale 1ns/1ps
module test_rt_reaction_timer;
    localparam int CLK_HZ = 4000;
    localparam int DIV    = CLK_HZ / 1000;
    localparam int MIN_D  = 4;
    localparam int SPAN_D = 8;
    localparam int NVEC   = 8;

    localparam int          WAIT_TAB [NVEC] = '{0, 3, 4, 7, 41, 402, 3998, 3999};
    localparam logic [15:0] EXP_TAB  [NVEC] = '{16'h0000, 16'h0000, 16'h0001, 16'h0001,
                                                16'h0010, 16'h0100, 16'h0999, 16'h0999};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        stim_o, done_o, timeout_o, false_start_o;
    logic [15:0] bcd_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rt_reaction_timer #(
        .CLK_HZ       (CLK_HZ),
        .MIN_DELAY_MS (MIN_D),
        .DELAY_SPAN_MS(SPAN_D),
        .LFSR_SEED    (16'h5A3C)
    ) i_rt_reaction_timer (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .stim_o       (stim_o),
        .bcd_o        (bcd_o),
        .done_o       (done_o),
        .timeout_o    (timeout_o),
        .false_start_o(false_start_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic press_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(bcd_o == 16'h0000 && !done_o && !stim_o && !timeout_o && !false_start_o,
            "R2 start clears", {12'h0, done_o, stim_o, timeout_o, false_start_o, bcd_o}, 32'h0);
    endtask

    task automatic wait_stim();
        int cyc = 0;
        while (!stim_o && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(stim_o && (cyc % DIV == 0) && (cyc >= MIN_D * DIV) && (cyc <= (MIN_D + SPAN_D - 1) * DIV),
            "R3 cue delay", cyc, MIN_D * DIV);
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bcd_o == 16'h0000 && !stim_o && !done_o && !timeout_o && !false_start_o,
            "R1 reset", {12'h0, done_o, stim_o, timeout_o, false_start_o, bcd_o}, 32'h0);

        // R8 stop ignored while idle
        pulse_stop();
        repeat (3) @(negedge clk);
        chk(bcd_o == 16'h0000 && !done_o && !stim_o && !false_start_o,
            "R8 idle stop", {done_o, false_start_o, bcd_o}, 32'h0);

        // table of response delays and expected frozen results (R5)
        for (int i = 0; i < NVEC; i++) begin
            press_start();
            wait_stim();
            repeat (WAIT_TAB[i]) @(negedge clk);
            pulse_stop();
            chk(done_o && !stim_o && !timeout_o && bcd_o == EXP_TAB[i],
                "R5 response", {15'h0, done_o, bcd_o}, {15'h0, 1'b1, EXP_TAB[i]});
        end

        // R8 stop ignored once done
        pulse_stop();
        repeat (5) @(negedge clk);
        chk(done_o && bcd_o == 16'h0999 && !false_start_o && !timeout_o,
            "R8 done stop", bcd_o, 16'h0999);

        // R4 live count while lamp lit
        press_start();
        wait_stim();
        repeat (41) @(negedge clk);
        chk(stim_o && bcd_o == 16'h0010, "R4 live count", bcd_o, 16'h0010);
        repeat (400 - 41) @(negedge clk);
        chk(stim_o && bcd_o == 16'h0100, "R4 hundreds carry", bcd_o, 16'h0100);

        // R9 start and stop together while measuring
        start_i = 1'b1;
        stop_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
        chk(!done_o && !stim_o && bcd_o == 16'h0000 && !false_start_o,
            "R9 start wins", {done_o, stim_o, bcd_o}, 32'h0);
        wait_stim();

        // R6 timeout at 1000 ms
        repeat (4000 - 1) @(negedge clk);
        chk(stim_o && !done_o && bcd_o == 16'h0999, "R6 before limit", bcd_o, 16'h0999);
        @(negedge clk);
        chk(done_o && timeout_o && !stim_o && bcd_o == 16'h1000,
            "R6 timeout", {14'h0, done_o, timeout_o, bcd_o}, {14'h0, 2'b11, 16'h1000});

        // R7 false start
        press_start();
        repeat (2) @(negedge clk);
        pulse_stop();
        chk(done_o && false_start_o && !stim_o && !timeout_o && bcd_o == 16'h9999,
            "R7 false start", {14'h0, done_o, false_start_o, bcd_o}, {14'h0, 2'b11, 16'h9999});
        repeat (100) @(negedge clk);
        chk(!stim_o && bcd_o == 16'h9999 && false_start_o, "R7 lamp stays off", {stim_o, bcd_o}, 32'h9999);

        // R2 re-arm after false start clears flags
        press_start();
        wait_stim();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule